// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Controller

This block is the slave side of a two-wire serial memory device. It watches the clock and data lines of the bus, which a master drives, on a faster system clock. It recognises the start and stop framing conditions and decodes a device-select byte against its chip-address pins. After each byte that belongs to it, the block acknowledges by pulling the data line low. It fronts a byte-addressed register array of 128, 256 or 512 bytes. The only output toward the bus is a drive-low enable, so the data pin can be built as an open-drain pad.

A write transfer carries a device-select byte with the direction bit clear, a word address and one or more data bytes. The block holds one pending byte. When the stop condition arrives, an internal programming interval of a set number of system clocks begins, and the byte is committed to the array at the end of that interval. While the interval runs, the device stays silent on the bus. A read transfer shifts out the byte at the current address, most significant bit first. It keeps going while the master acknowledges and ends as soon as the master withholds acknowledge. A random read is made by loading the word address in a write transfer and then issuing a repeated start with the direction bit set.

Top module: `twi_eeprom_slave`

## Requirements
- R1: After reset the drive-low output is 0 and every byte of the memory array reads as 0x00.
- R2: Bus activity is decoded only after a START, which is SDA falling while SCL is high. Bytes clocked on the bus without a preceding START get no acknowledge.
- R3: A device-select byte is accepted only when its upper nibble is 1010 and bits 3..1 equal chip_addr[2:0]. Otherwise the block gives no acknowledge to that byte, or to any later byte, until the next START.
- R4: The acknowledge for an accepted device-select byte, a word-address byte or a write-data byte holds the bus low for the whole high phase of the ninth SCL pulse.
- R5: In a write, the byte after the device-select byte is the word address. Each data byte is stored at the current address, and the address then advances. Only one byte is held pending, so after STOP the last data byte of the transfer is written at its own address once PROG_CYCLES system clocks have passed.
- R6: While the programming interval runs, a device-select byte gets no acknowledge and the block never drives the bus low.
- R7: A read returns the byte at the current address, most significant bit first. The block changes its drive only while SCL is low. Each byte the master acknowledges is followed by the byte at the next address.
- R8: When the master does not acknowledge a read byte, the block releases the bus and keeps it released until the next START.
- R9: The address wraps from MEM_BYTES-1 to 0, for both reads and writes.
- R10: A START in the middle of a byte abandons that byte and restarts device-select decoding. The word address already loaded is kept, so a random read can follow.
- R11: With MEM_BYTES = 512, only chip_addr[2:1] are compared, and bit 1 of the device-select byte becomes address bit 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Serial clock as seen on the bus |
| sda_in | input | 1 | Serial data as seen on the bus (wired-AND of all drivers) |
| chip_addr | input | 3 | Chip-address strap pins, bit 2 most significant |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The assertions assume that every SCL high and low phase lasts several system clocks. They also assume that the master moves SDA only while SCL is low, except when it forms START and STOP, and that it never issues START or STOP while this block is pulling the line low. On those terms, a drive change that lines up with SCL high, or a bus pull-down outside an acknowledge slot or a read bit, points to a fault in the block. The bench master holds each SCL phase for 12 to 16 system clocks. It moves SDA four clocks after the SCL fall, after the slave has updated its own drive. It issues STOP or repeated START only after the slave has released the line. It puts two slaves of different sizes on one wired-AND bus to check address separation.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // Fixed device-type nibble in the device-select byte
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEVSEL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA
  } tw_state_t;
endpackage

// File: rtl/tw_bus_sampler.sv
module tw_bus_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic start_evt,
  output logic stop_evt,
  output logic scl_rise,
  output logic scl_fall
);
  localparam int LAST = SYNC_STAGES - 1;

  // bit 1 = SCL, bit 0 = SDA
  logic [1:0] stg [SYNC_STAGES];
  logic       scl_p, sda_p;

  genvar k;
  generate
    for (k = 0; k < SYNC_STAGES; k++) begin : g_sync
      if (k == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[k] <= 2'b11;
          else        stg[k] <= {scl_in, sda_in};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[k] <= 2'b11;
          else        stg[k] <= stg[k-1];
        end
      end
    end
  endgenerate

  assign scl_s = stg[LAST][1];
  assign sda_s = stg[LAST][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_evt = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/tw_prog_timer.sv
module tw_prog_timer #(
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(PROG_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PROG_CYCLES);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  remain <= '0;
    else if (start && !busy)     remain <= LOAD;
    else if (remain != '0)       remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
  assign done = (remain == CW'(1));

  // R6
  timer_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= LOAD);
endmodule

// File: rtl/tw_mem.sv
module tw_mem #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= 8'h00;
    end else if (we) begin
      cells[waddr] <= wdata;
    end
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/twi_eeprom_slave.sv
module twi_eeprom_slave
  import tw_pkg::*;
#(
  parameter int MEM_BYTES   = 256,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] chip_addr,
  output logic       sda_drive_low
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam bit WIDE   = (ADDR_W > 8);

  // ---- arithmetic helpers ----
  function automatic logic dev_match(input logic [7:0] b, input logic [2:0] pins);
    logic ok;
    ok = (b[7:4] == DEV_CODE) && (b[3:2] == pins[2:1]);
    if (!WIDE) ok = ok && (b[1] == pins[0]);
    return ok;
  endfunction

  function automatic logic [ADDR_W-1:0] addr_next(input logic [ADDR_W-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [ADDR_W-1:0] load_word(input logic [ADDR_W-1:0] cur,
                                                  input logic [7:0] b);
    logic [ADDR_W-1:0] r;
    r = cur;
    for (int i = 0; i < ADDR_W && i < 8; i++) r[i] = b[i];
    return r;
  endfunction

  function automatic logic [ADDR_W-1:0] load_block(input logic [ADDR_W-1:0] cur,
                                                   input logic [7:0] b);
    logic [ADDR_W-1:0] r;
    r = cur;
    if (WIDE) r[ADDR_W-1] = b[1];
    return r;
  endfunction

  // ---- named internal events ----
  logic scl_s, sda_s, start_evt, stop_evt, scl_rise, scl_fall;
  logic busy, prog_done, prog_start;
  logic [7:0] mem_rd;

  tw_state_t         state;
  logic [7:0]        rx_sh, tx_sh;
  logic [3:0]        bit_cnt;
  logic              ack_phase, rd_dir, m_ack_low;
  logic [ADDR_W-1:0] addr;
  logic              pend_valid;
  logic [ADDR_W-1:0] pend_addr;
  logic [7:0]        pend_data;

  tw_bus_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .start_evt(start_evt), .stop_evt(stop_evt),
    .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  tw_prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy), .done(prog_done)
  );

  tw_mem #(.DEPTH(MEM_BYTES), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(prog_done), .waddr(pend_addr), .wdata(pend_data),
    .raddr(addr), .rdata(mem_rd)
  );

  wire is_tx        = (state == ST_RDATA);
  wire active       = (state != ST_IDLE);
  wire bit_sample   = active && scl_rise && !ack_phase && (bit_cnt < 4'd8);
  wire tx_shift     = active && is_tx && scl_fall && !ack_phase &&
                      (bit_cnt != 4'd0) && (bit_cnt != 4'd8);
  wire byte_done    = active && scl_fall && !ack_phase && (bit_cnt == 4'd8);
  wire slot_end     = active && scl_fall && ack_phase;
  wire sel_ok       = dev_match(rx_sh, chip_addr) && !busy;

  assign prog_start = stop_evt && pend_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      rx_sh         <= '0;
      tx_sh         <= '0;
      bit_cnt       <= '0;
      ack_phase     <= 1'b0;
      rd_dir        <= 1'b0;
      m_ack_low     <= 1'b0;
      addr          <= '0;
      pend_valid    <= 1'b0;
      pend_addr     <= '0;
      pend_data     <= '0;
      sda_drive_low <= 1'b0;
    end else if (start_evt) begin
      state         <= ST_DEVSEL;
      bit_cnt       <= '0;
      ack_phase     <= 1'b0;
      pend_valid    <= 1'b0;
      sda_drive_low <= 1'b0;
    end else if (stop_evt) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      ack_phase     <= 1'b0;
      sda_drive_low <= 1'b0;
      if (prog_start) pend_valid <= 1'b0;
    end else begin
      if (bit_sample) begin
        rx_sh   <= {rx_sh[6:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (active && scl_rise && ack_phase) m_ack_low <= !sda_s;
      if (tx_shift) begin
        tx_sh         <= {tx_sh[6:0], 1'b0};
        sda_drive_low <= !tx_sh[6];
      end
      if (byte_done) begin
        ack_phase <= 1'b1;
        unique case (state)
          ST_DEVSEL: begin
            if (sel_ok) begin
              sda_drive_low <= 1'b1;
              rd_dir        <= rx_sh[0];
              addr          <= load_block(addr, rx_sh);
            end else begin
              state     <= ST_IDLE;
              ack_phase <= 1'b0;
            end
          end
          ST_WADDR: begin
            sda_drive_low <= 1'b1;
            addr          <= load_word(addr, rx_sh);
          end
          ST_WDATA: begin
            sda_drive_low <= 1'b1;
            pend_valid    <= 1'b1;
            pend_addr     <= addr;
            pend_data     <= rx_sh;
            addr          <= addr_next(addr);
          end
          ST_RDATA: begin
            sda_drive_low <= 1'b0;
            addr          <= addr_next(addr);
          end
          default: ;
        endcase
      end
      if (slot_end) begin
        ack_phase     <= 1'b0;
        bit_cnt       <= '0;
        sda_drive_low <= 1'b0;
        unique case (state)
          ST_DEVSEL: begin
            if (rd_dir) begin
              state         <= ST_RDATA;
              tx_sh         <= mem_rd;
              sda_drive_low <= !mem_rd[7];
            end else begin
              state <= ST_WADDR;
            end
          end
          ST_WADDR: state <= ST_WDATA;
          ST_WDATA: state <= ST_WDATA;
          ST_RDATA: begin
            if (m_ack_low) begin
              tx_sh         <= mem_rd;
              sda_drive_low <= !mem_rd[7];
            end else begin
              state <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (state == ST_DEVSEL && bit_cnt == 4'd0 && !sda_drive_low));

  // R4
  ack_slot_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_drive_low && !is_tx) |-> ack_phase);

  // R5
  prog_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && pend_valid) |=> busy);

  // R6
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_drive_low);

  // R7
  drive_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_s);

  // R8
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_drive_low);
endmodule

// File: tb/twi_eeprom_slave_test.sv
module twi_eeprom_slave_test;
  localparam int PROG = 300;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic drv_n, drv_w;
  wire  sda_bus = m_sda & ~drv_n & ~drv_w;

  int checks = 0;
  int errors = 0;

  twi_eeprom_slave #(.MEM_BYTES(256), .PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .chip_addr(3'b001), .sda_drive_low(drv_n));

  twi_eeprom_slave #(.MEM_BYTES(512), .PROG_CYCLES(PROG)) uut_wide (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_bus),
    .chip_addr(3'b110), .sda_drive_low(drv_w));

  // {wide, address, data}
  localparam logic [17:0] VEC [8] = '{
    {1'b0, 9'h000, 8'h3C}, {1'b0, 9'h055, 8'hC3},
    {1'b0, 9'h0FE, 8'h01}, {1'b0, 9'h080, 8'h80},
    {1'b1, 9'h000, 8'h11}, {1'b1, 9'h100, 8'h22},
    {1'b1, 9'h1FF, 8'h9E}, {1'b1, 9'h0AA, 8'h77}};

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] dsel(input logic wide, input logic [8:0] a, input logic rd);
    return wide ? {4'hA, 2'b11, a[8], rd} : {4'hA, 3'b001, rd};
  endfunction

  task automatic bus_start();
    w(4); m_sda = 1'b1; w(8); m_scl = 1'b1; w(12); m_sda = 1'b0; w(12); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    w(4); m_sda = 1'b0; w(8); m_scl = 1'b1; w(12); m_sda = 1'b1; w(12);
  endtask

  task automatic send_bit(input logic b);
    w(4); m_sda = b; w(8); m_scl = 1'b1; w(16); m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic a1, a2;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    w(4); m_sda = 1'b1; w(8); m_scl = 1'b1;
    w(4); a1 = sda_bus; w(10); a2 = sda_bus; w(2); m_scl = 1'b0;
    acked = !a1 && !a2;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b, output logic stable);
    logic s1, s2;
    stable = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      w(4); m_sda = 1'b1; w(8); m_scl = 1'b1;
      w(4); s1 = sda_bus; w(10); s2 = sda_bus; w(2); m_scl = 1'b0;
      b = {b[6:0], s1};
      if (s1 !== s2) stable = 1'b0;
    end
    w(4); m_sda = !give_ack; w(8); m_scl = 1'b1; w(16); m_scl = 1'b0;
  endtask

  task automatic write_bytes(input logic wide, input logic [8:0] a, input int n,
                             input logic [7:0] d0, input logic [7:0] d1);
    logic ack;
    bus_start();
    send_byte(dsel(wide, a, 1'b0), ack); check("R4 ack device select (write)", ack, 1);
    send_byte(a[7:0], ack);               check("R4 ack word address", ack, 1);
    send_byte(d0, ack);                   check("R4 ack data byte", ack, 1);
    if (n > 1) begin
      send_byte(d1, ack);                 check("R4 ack second data byte", ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic wide, input logic [8:0] a, input int n,
                          output logic [7:0] r0, output logic [7:0] r1);
    logic ack, st;
    r1 = '0;
    bus_start();
    send_byte(dsel(wide, a, 1'b0), ack); check("R4 ack device select (addr)", ack, 1);
    send_byte(a[7:0], ack);               check("R4 ack read word address", ack, 1);
    bus_start();
    send_byte(dsel(wide, a, 1'b1), ack); check("R4 ack device select (read)", ack, 1);
    recv_byte(n > 1, r0, st);             check("R7 data stable while SCL high", st, 1);
    if (n > 1) begin
      recv_byte(1'b0, r1, st);            check("R7 data stable on second byte", st, 1);
    end
    bus_stop();
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    logic [7:0] r0, r1, rb;
    logic ack, st;
    logic [17:0] v;

    w(10); rst_n = 1'b1; w(10);
    // R1 reset state
    check("R1 drive released after reset", {drv_n, drv_w}, 0);
    read_seq(1'b0, 9'h010, 1, r0, r1);
    check("R1 memory cleared", r0, 8'h00);

    // R2: bytes without START are ignored
    w(4); m_scl = 1'b0;
    send_byte(8'hA2, ack);
    check("R2 no ack without START", ack, 0);
    bus_stop();

    // R3: wrong device code, then following byte also ignored
    bus_start();
    send_byte(8'hB2, ack); check("R3 wrong code not acked", ack, 0);
    send_byte(8'h00, ack); check("R3 later byte ignored", ack, 0);
    bus_stop();
    bus_start();
    send_byte(8'hA0, ack); check("R3 wrong chip pins not acked", ack, 0);
    bus_stop();

    // Table of write / read-back vectors (R5, R11)
    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      write_bytes(v[17], v[16:8], 1, v[7:0], 8'h00);
      w(PROG + 40);
      read_seq(v[17], v[16:8], 1, r0, r1);
      if (v[17]) check("R11 wide device readback", r0, v[7:0]);
      else       check("R5 written byte readback", r0, v[7:0]);
    end
    read_seq(1'b1, 9'h000, 1, r0, r1);
    check("R11 lower block kept apart from upper block", r0, 8'h11);

    // R6: silent during programming
    write_bytes(1'b0, 9'h020, 1, 8'h5E, 8'h00);
    bus_start();
    send_byte(8'hA2, ack); check("R6 no ack while programming", ack, 0);
    bus_stop();
    w(PROG + 40);
    read_seq(1'b0, 9'h020, 1, r0, r1);
    check("R5 byte committed after interval", r0, 8'h5E);

    // R9 + R5: two bytes from 0xFF, only the last is kept, at address 0x00
    write_bytes(1'b0, 9'h0FF, 2, 8'hAB, 8'hCD);
    w(PROG + 40);
    read_seq(1'b0, 9'h0FF, 2, r0, r1);
    check("R5 only last pending byte stored", r0, 8'h00);
    check("R9 address wraps to zero", r1, 8'hCD);

    // R7: sequential read continues while master acknowledges
    read_seq(1'b0, 9'h054, 2, r0, r1);
    check("R7 first byte of sequential read", r0, 8'h00);
    check("R7 next address after master ack", r1, 8'hC3);

    // R8: after master NACK the bus stays released
    bus_start();
    send_byte(8'hA2, ack);
    send_byte(8'h55, ack);
    bus_start();
    send_byte(8'hA3, ack);
    recv_byte(1'b0, r0, st);
    check("R8 byte before NACK", r0, 8'hC3);
    recv_byte(1'b0, rb, st);
    check("R8 bus released after NACK", rb, 8'hFF);
    bus_stop();

    // R10: START in the middle of a data byte restarts decoding
    bus_start();
    send_byte(8'hA2, ack);
    send_byte(8'h55, ack);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
    bus_start();
    send_byte(8'hA3, ack); check("R10 device select acked after restart", ack, 1);
    recv_byte(1'b0, r0, st);
    check("R10 random read after mid-byte restart", r0, 8'hC3);
    bus_stop();
    w(PROG + 40);
    read_seq(1'b0, 9'h055, 1, r0, r1);
    check("R10 aborted byte not written", r0, 8'hC3);

    report();
    $finish;
  end
endmodule